// File: doc/BRIEF.md
# Modem Control Loopback Unit

This unit sits in the control path of a serial port and implements its loopback mode. The loopback-enable bit of the control register selects the mode. While it is set, the modem control outputs that software writes come straight back as modem status flags, with each output mapped onto a different status input. Each such control write also produces clear and set strobes for the modem-status raw interrupt bits. Characters written for transmission, and rising edges of the send-break bit in line control, are turned into push requests for the receive FIFO. Characters and break events arriving from the line are dropped.

While loopback is clear, control writes leave the modem flags and interrupts alone. External characters and external breaks then become the receive FIFO push requests. The unit works at the character level, with no serial bit timing. Every push request and interrupt strobe is a combinational result of the write or event in the same cycle. The flags take their new value at the clock edge that ends that cycle.

The surrounding port logic owns the receive FIFO and the raw interrupt register. It applies the clear strobe before the set strobe, and accepts at most one push per cycle.

Top module: `modem_loop_unit`

## Requirements
- R1: After a synchronous active-low reset, loopback is off, the modem flags read 0, and neither a push nor an interrupt strobe is active.
- R2: A control write with bit 0 (loopback enable) set loads the modem flags at the next clock edge as follows: flag bit 0 (clear-to-send) from control bit 2 (request-to-send), flag bit 1 (data-set-ready) from control bit 1 (data-terminal-ready), flag bit 2 (carrier detect) from control bit 3 (out1), and flag bit 3 (ring indicator) from control bit 4 (out2).
- R3: The mapping of R2 also applies when loopback was off before the write, so a write that only turns loopback on updates the flags at once.
- R4: In the cycle of a control write with bit 0 set, the interrupt clear strobe is 4'b1111. In the same cycle the interrupt set strobe equals the new flag value, in the flag bit order of R2.
- R5: A control write with bit 0 clear leaves the modem flags unchanged, and both interrupt strobes stay 0.
- R6: With loopback on, a transmit data write raises a push in the same cycle. The push carries the written byte and a clear break marker.
- R7: With loopback on, a line-control write that sets send-break while send-break was clear raises a push with the break marker set and data 0. A write that keeps send-break set, or clears it, pushes nothing.
- R8: With loopback on, when a transmit write and a send-break rise arrive in the same cycle, only the transmit data is pushed.
- R9: With loopback on, external received characters and external break events push nothing.
- R10: With loopback off, an external character pushes its data with the break marker clear. An external break alone pushes a break-marked entry with data 0, a character arriving in the same cycle wins, and transmit writes and send-break rises push nothing.
- R11: The loopback state follows bit 0 of the most recent control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write value: {out2, out1, rts, dtr, loopback} |
| tx_we | input | 1 | Transmit data write strobe |
| tx_wdata | input | 8 | Transmit data byte |
| lcr_we | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Send-break value carried by the line-control write |
| ext_rx_valid | input | 1 | Character received from the line |
| ext_rx_data | input | 8 | Received character |
| ext_brk | input | 1 | Break event seen on the line |
| modem_flags | output | 4 | {ri, dcd, dsr, cts} status flags |
| ms_int_set | output | 4 | Modem-status raw interrupt set strobe |
| ms_int_clr | output | 4 | Modem-status raw interrupt clear strobe |
| push_valid | output | 1 | Receive FIFO push request |
| push_data | output | 8 | Data for the pushed entry |
| push_brk | output | 1 | Break marker for the pushed entry |

## Verification
The bench writes all 32 control values from both a looped and a non-looped starting state. This separates the enable-only update case (R3) from steady loopback (R2) and from writes that must change nothing (R5), and it exposes any swapped pair in the cross mapping. The push path is driven with all 32 combinations of transmit write, line-control write, send-break value, external character and external break, in both modes. The send-break history carries over between combinations, so held, rising and falling breaks all occur. This shows the source priority, the blocking of external input and the edge-only break push.

// File: rtl/ml_pkg.sv
// Package: shared field positions and source selectors for the modem
// loopback unit. Assumes a 5-bit control write image and 4 modem flags.
package ml_pkg;
    localparam int CTRL_W   = 5;
    localparam int LBE_BIT  = 0;
    localparam int DTR_BIT  = 1;
    localparam int RTS_BIT  = 2;
    localparam int OUT1_BIT = 3;
    localparam int OUT2_BIT = 4;
    localparam int NMODEM   = 4;

    // Flag bit order of the modem status vector.
    typedef enum int {MS_CTS = 0, MS_DSR = 1, MS_DCD = 2, MS_RI = 3} modem_bit_e;

    // Which source wins the receive FIFO push in a given cycle.
    typedef enum logic [2:0] {
        PSH_NONE, PSH_TX, PSH_LBRK, PSH_EXT, PSH_EBRK
    } push_src_e;

    // Control bit that drives each modem flag while looped back.
    function automatic int loop_src(input int flag_idx);
        case (flag_idx)
            MS_CTS:  return RTS_BIT;
            MS_DSR:  return DTR_BIT;
            MS_DCD:  return OUT1_BIT;
            default: return OUT2_BIT;
        endcase
    endfunction
endpackage

// File: rtl/ml_modem_loop.sv
// Module: holds the loopback enable and the modem status flags. A control
// write with the loopback bit set copies the cross-mapped outputs onto the
// flags and emits clear-all / set strobes for the modem interrupts.
// Assumes the caller applies clear before set.
module ml_modem_loop
    import ml_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              lb_en,
    output logic [NMODEM-1:0] modem_flags,
    output logic [NMODEM-1:0] ms_int_set,
    output logic [NMODEM-1:0] ms_int_clr
);
    logic              upd;
    logic [NMODEM-1:0] mapped;

    assign upd = ctrl_we & ctrl_wdata[LBE_BIT];

    // Cross-map each modem output onto its status flag.
    for (genvar i = 0; i < NMODEM; i++) begin : g_map
        assign mapped[i] = ctrl_wdata[loop_src(i)];
    end

    // Loopback enable follows every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       lb_en <= 1'b0;
        else if (ctrl_we) lb_en <= ctrl_wdata[LBE_BIT];
    end

    // Modem flags load only on a looped-back control write.
    always_ff @(posedge clk) begin
        if (!rst_n)   modem_flags <= '0;
        else if (upd) modem_flags <= mapped;
    end

    // Interrupt strobes: clear every modem bit, then set from new flags.
    always_comb begin
        ms_int_clr = {NMODEM{upd}};
        ms_int_set = upd ? mapped : '0;
    end

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_wdata[LBE_BIT]) |=> $stable(modem_flags));
    a_r11_lb_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (lb_en == $past(ctrl_wdata[LBE_BIT])));
    a_r2_cts_from_rts: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[LBE_BIT]) |=> (modem_flags[MS_CTS] == $past(ctrl_wdata[RTS_BIT])));
    a_r2_ri_from_out2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[LBE_BIT]) |=> (modem_flags[MS_RI] == $past(ctrl_wdata[OUT2_BIT])));
endmodule

// File: rtl/ml_break_edge.sv
// Module: remembers the last written send-break value and flags a
// line-control write that raises it. Assumes one write per cycle.
module ml_break_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lcr_we,
    input  logic lcr_brk,
    output logic brk_rise
);
    logic brk_q;

    // Track the current send-break setting.
    always_ff @(posedge clk) begin
        if (!rst_n)      brk_q <= 1'b0;
        else if (lcr_we) brk_q <= lcr_brk;
    end

    // A rise is a write of 1 over a stored 0.
    always_comb brk_rise = lcr_we & lcr_brk & ~brk_q;

    a_r7_no_double_rise: assert property (@(posedge clk) disable iff (!rst_n)
        brk_rise |=> !brk_rise);
endmodule

// File: rtl/ml_push_sel.sv
// Module: picks the single receive FIFO push source for the cycle. In
// loopback, transmit data beats a send-break rise and line input is
// dropped. Otherwise a line character beats a line break. Purely
// combinational; clk and rst_n serve only the assertions.
module ml_push_sel
    import ml_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_en,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              brk_rise,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_brk,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_brk
);
    push_src_e src;

    // Priority choice of the push source.
    always_comb begin
        src = PSH_NONE;
        if (lb_en) begin
            if (tx_we)         src = PSH_TX;
            else if (brk_rise) src = PSH_LBRK;
        end else begin
            if (ext_rx_valid)  src = PSH_EXT;
            else if (ext_brk)  src = PSH_EBRK;
        end
    end

    // Form the pushed entry from the chosen source.
    always_comb begin
        push_valid = (src != PSH_NONE);
        push_brk   = (src == PSH_LBRK) || (src == PSH_EBRK);
        case (src)
            PSH_TX:  push_data = tx_wdata;
            PSH_EXT: push_data = ext_rx_data;
            default: push_data = '0;
        endcase
    end

    a_r9_line_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_en && !tx_we && !brk_rise) |-> !push_valid);
    a_r6_tx_looped: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_en && tx_we) |-> (push_valid && !push_brk && push_data == tx_wdata));
    a_r10_line_char: assert property (@(posedge clk) disable iff (!rst_n)
        (!lb_en && ext_rx_valid) |-> (push_valid && !push_brk && push_data == ext_rx_data));
endmodule

// File: rtl/modem_loop_unit.sv
// Module: top of the modem control loopback unit. Ties the flag/enable
// state, the send-break edge detector and the push source selector.
// Assumes the surrounding port owns the receive FIFO and interrupt bits.
module modem_loop_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [4:0]        ctrl_wdata,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              lcr_we,
    input  logic              lcr_brk,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_brk,
    output logic [3:0]        modem_flags,
    output logic [3:0]        ms_int_set,
    output logic [3:0]        ms_int_clr,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_brk
);
    logic lb_en;
    logic brk_rise;

    ml_modem_loop u_modem (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .lb_en(lb_en), .modem_flags(modem_flags),
        .ms_int_set(ms_int_set), .ms_int_clr(ms_int_clr)
    );

    ml_break_edge u_brk (
        .clk(clk), .rst_n(rst_n), .lcr_we(lcr_we), .lcr_brk(lcr_brk),
        .brk_rise(brk_rise)
    );

    ml_push_sel #(.DATA_W(DATA_W)) u_push (
        .clk(clk), .rst_n(rst_n), .lb_en(lb_en),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .brk_rise(brk_rise),
        .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_brk(ext_brk),
        .push_valid(push_valid), .push_data(push_data), .push_brk(push_brk)
    );

    a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|ms_int_clr) |=> (modem_flags == $past(ms_int_set)));
    a_r7_brk_marker_empty: assert property (@(posedge clk) disable iff (!rst_n)
        push_brk |-> (push_valid && push_data == '0));
endmodule

// File: tb/tb_modem_loop_unit.sv
`timescale 1ns/1ps
module tb_modem_loop_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       lcr_we = 1'b0;
    logic       lcr_brk = 1'b0;
    logic       ext_rx_valid = 1'b0;
    logic [7:0] ext_rx_data = '0;
    logic       ext_brk = 1'b0;
    logic [3:0] modem_flags, ms_int_set, ms_int_clr;
    logic       push_valid, push_brk;
    logic [7:0] push_data;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  m_lb = 1'b0;
    bit  m_brk = 1'b0;
    logic [3:0] m_flags = '0;

    modem_loop_unit dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] map(input logic [4:0] v);
        return {v[4], v[3], v[1], v[2]};
    endfunction

    task automatic ctrl_write(input logic [4:0] v, input bit prior_lb);
        string tag;
        tag = v[0] ? (prior_lb ? "R2" : "R3") : "R5";
        ctrl_we = 1'b1; ctrl_wdata = v;
        #1;
        chk(ms_int_clr == (v[0] ? 4'hF : 4'h0), v[0] ? "R4" : "R5", ms_int_clr, v[0] ? 4'hF : 4'h0);
        chk(ms_int_set == (v[0] ? map(v) : 4'h0), v[0] ? "R4" : "R5", ms_int_set, v[0] ? map(v) : 4'h0);
        chk(!push_valid, "R5", push_valid, 0);
        @(posedge clk); #1;
        ctrl_we = 1'b0;
        m_lb = v[0];
        if (v[0]) m_flags = map(v);
        chk(modem_flags == m_flags, tag, modem_flags, m_flags);
    endtask

    task automatic push_cycle(input logic [4:0] c, input logic [7:0] td, input logic [7:0] rd);
        bit ev, eb;
        logic [7:0] ed;
        string tag;
        tx_we = c[0]; tx_wdata = td; lcr_we = c[1]; lcr_brk = c[2];
        ext_rx_valid = c[3]; ext_rx_data = rd; ext_brk = c[4];
        ev = 0; eb = 0; ed = '0;
        if (m_lb) begin
            tag = (c[0] && c[1] && c[2] && !m_brk) ? "R8" : (c[0] ? "R6" : (c[1] ? "R7" : "R9"));
            if (c[0]) begin ev = 1; ed = td; end
            else if (c[1] && c[2] && !m_brk) begin ev = 1; eb = 1; end
        end else begin
            tag = "R10";
            if (c[3]) begin ev = 1; ed = rd; end
            else if (c[4]) begin ev = 1; eb = 1; end
        end
        #1;
        chk(push_valid == ev && push_brk == eb && push_data == ed, tag,
            {push_valid, push_brk, push_data}, {ev, eb, ed});
        chk(ms_int_clr == 4'h0, tag, ms_int_clr, 0);
        @(posedge clk); #1;
        if (c[1]) m_brk = c[2];
        tx_we = 0; lcr_we = 0; ext_rx_valid = 0; ext_brk = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(modem_flags == 4'h0, "R1", modem_flags, 0);
        chk(!push_valid && ms_int_clr == 0 && ms_int_set == 0, "R1", push_valid, 0);
        tx_we = 1'b1; tx_wdata = 8'h5A;
        #1;
        chk(!push_valid, "R1", push_valid, 0);
        tx_we = 1'b0;
        @(posedge clk); #1;

        // Exhaustive control sweep from both starting modes (R2 R3 R4 R5)
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 32; v++) begin
                ctrl_write(5'(p == 1 ? 5'h1F : 5'h1E), m_lb);
                ctrl_write(5'(v), m_lb);
            end
        end

        // Push path sweep in both modes (R6 R7 R8 R9 R10 R11)
        for (int mode = 0; mode < 2; mode++) begin
            ctrl_write(5'(mode == 1 ? 5'h15 : 5'h0A), m_lb);
            for (int rep = 0; rep < 2; rep++) begin
                for (int c = 0; c < 32; c++) begin
                    push_cycle(5'(c), 8'(c * 37 + 5 + rep), 8'(c * 91 + 3 + rep));
                end
            end
        end

        // R11: state tracks last write, flags kept across a disabling write
        ctrl_write(5'h1F, m_lb);
        ctrl_write(5'h00, m_lb);
        push_cycle(5'b00001, 8'hC3, 8'h11);
        ctrl_write(5'h01, m_lb);
        push_cycle(5'b01001, 8'h3C, 8'h22);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule